// File: doc/BRIEF.md
# Reset Boot Address Selector

This block chooses where the processor fetches its first instruction after a reset. When the chip reset is released, it waits a fixed settling period. It then reads two bytes from the non-volatile store through a simple request/ready read port: first a boot status byte, then an 8-bit boot vector. If the status byte is zero, the processor starts at address 16'h0000, where the user application lives. Any other status value sends the processor to the boot vector used as the high address byte, with a low byte of zero. With the factory vector of 8'h1F, that start address is 16'h1F00. This address is the entry of the default loader, which fills 16'h1E00 to 16'h1FFF inside the top 1 KB sector (16'h1C00 to 16'h1FFF).

A hardware force-loader input is sampled once, just after reset release. When it is high, the block behaves exactly as if the status byte were nonzero. The processor is kept in reset while the decision is made. The chosen address is placed on the output one cycle before the processor is released, so the processor sees a settled value when it leaves reset.

Top module: `boot_addr_sel`

## Requirements
- R1: When the status byte is 8'h00 and force was not latched, the final start address is 16'h0000.
- R2: When any bit of the status byte is 1, the final start address is {vector byte, 8'h00}. For example, vector 8'h1F gives 16'h1F00 and vector 8'h00 gives 16'h0000.
- R3: If force_ldr_i is high at the first clock edge after the internal reset is released (the edge at which the synchronised reset first reads high), the final address is {vector byte, 8'h00} even when the status byte is zero.
- R4: Changes of force_ldr_i after that first edge have no effect on the final address until the next reset.
- R5: After rst_n rises, flash_req_o stays low for 2 synchroniser cycles plus WAIT_CYC cycles, and then rises. The first read uses flash_addr_o = STATUS_LOC (default 4'h0). The second read uses VECTOR_LOC (default 4'h1). Each request holds its address until a cycle in which flash_rdy_i is high, and flash_data_i is taken in that cycle.
- R6: boot_addr_o takes its final value at the clock edge that completes the vector read. cpu_rst_n_o rises exactly one clock edge later, and boot_addr_o does not change while cpu_rst_n_o is high.
- R7: Once cpu_rst_n_o is high, it stays high and flash_req_o stays low until the next reset.
- R8: While rst_n is low, cpu_rst_n_o is 0, flash_req_o is 0 and boot_addr_o is 16'h0000, and this takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| force_ldr_i | input | 1 | Hardware request to enter the loader |
| flash_req_o | output | 1 | Read request to the non-volatile store |
| flash_addr_o | output | FA_W | Location being read |
| flash_rdy_i | input | 1 | Read data valid; completes the request |
| flash_data_i | input | DATA_W | Read data |
| cpu_rst_n_o | output | 1 | Active-low reset to the processor |
| boot_addr_o | output | ADDR_W | First fetch address for the processor |

## Verification
The bench targets several corner cases, each with the failure a wrong design would show:
- A status byte with only its top bit set. A design that tests only the low bit would start at 16'h0000 instead of following the vector.
- A vector of 8'h00 combined with a nonzero status. This separates "use the vector" from "use address zero" only through the vector value itself.
- Force held high at release and then dropped, or raised only after release. A design that keeps sampling the pin would change the start address in the second case.
- Zero-latency and multi-cycle flash reads. A design that takes data before ready, or mixes up the two locations, would produce the wrong address.

The bench also applies a reset in the middle of the vector read. A design whose reset path goes through the clock would keep the processor released or the request high.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;
  typedef enum logic [1:0] {
    ST_RESET_WAIT  = 2'd0,
    ST_READ_STATUS = 2'd1,
    ST_READ_VECTOR = 2'd2,
    ST_RELEASE     = 2'd3
  } boot_state_e;
endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = 1'b1;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_sel_pkg::*;
#(
  parameter int          WAIT_CYC   = 4,
  parameter int          FA_W       = 4,
  parameter int          DATA_W     = 8,
  parameter logic [FA_W-1:0] STATUS_LOC = '0,
  parameter logic [FA_W-1:0] VECTOR_LOC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              force_i,
  input  logic              rdy_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              req_o,
  output logic [FA_W-1:0]   addr_o,
  output logic              use_vec_o,
  output logic              vec_load_o,
  output boot_state_e       state_o
);
  localparam int CNT_W = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);

  boot_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             taken_q, force_q, force_en;
  logic             stat_nz_q, stat_en;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    cnt_en     = 1'b0;
    force_en   = 1'b0;
    stat_en    = 1'b0;
    req_o      = 1'b0;
    addr_o     = STATUS_LOC;
    vec_load_o = 1'b0;
    unique case (state_q)
      ST_RESET_WAIT: begin
        force_en = !taken_q;
        cnt_en   = 1'b1;
        if (cnt_q == CNT_LAST) begin
          cnt_d   = '0;
          state_d = ST_READ_STATUS;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_READ_STATUS: begin
        req_o  = 1'b1;
        addr_o = STATUS_LOC;
        if (rdy_i) begin
          stat_en = 1'b1;
          state_d = ST_READ_VECTOR;
        end
      end
      ST_READ_VECTOR: begin
        req_o  = 1'b1;
        addr_o = VECTOR_LOC;
        if (rdy_i) begin
          vec_load_o = 1'b1;
          state_d    = ST_RELEASE;
        end
      end
      ST_RELEASE: begin
        state_d = ST_RELEASE;
      end
      default: state_d = ST_RESET_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RESET_WAIT;
      cnt_q     <= '0;
      taken_q   <= 1'b0;
      force_q   <= 1'b0;
      stat_nz_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (force_en) begin
        force_q <= force_i;
        taken_q <= 1'b1;
      end
      if (stat_en) stat_nz_q <= |data_i;
    end
  end

  assign use_vec_o = stat_nz_q | force_q;
  assign state_o   = state_q;
endmodule

// File: rtl/boot_addr_pick.sv
module boot_addr_pick
  import boot_sel_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vec_load_i,
  input  logic              use_vec_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  boot_state_e       state_i,
  output logic [ADDR_W-1:0] boot_addr_o,
  output logic              cpu_rst_n_o
);
  localparam int LOW_W = ADDR_W - VEC_W;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rel_q;

  always_comb begin
    addr_d = use_vec_i ? {vec_i, {LOW_W{1'b0}}} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rel_q  <= 1'b0;
    end else begin
      if (vec_load_i) addr_q <= addr_d;
      rel_q <= (state_i == ST_RELEASE);
    end
  end

  assign boot_addr_o = addr_q;
  assign cpu_rst_n_o = rel_q;
endmodule

// File: rtl/boot_addr_sel.sv
module boot_addr_sel
  import boot_sel_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter int              DATA_W      = 8,
  parameter int              FA_W        = 4,
  parameter int              WAIT_CYC    = 4,
  parameter int              SYNC_STAGES = 2,
  parameter logic [FA_W-1:0] STATUS_LOC  = '0,
  parameter logic [FA_W-1:0] VECTOR_LOC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              force_ldr_i,
  output logic              flash_req_o,
  output logic [FA_W-1:0]   flash_addr_o,
  input  logic              flash_rdy_i,
  input  logic [DATA_W-1:0] flash_data_i,
  output logic              cpu_rst_n_o,
  output logic [ADDR_W-1:0] boot_addr_o
);
  logic        rst_sync_n;
  logic        use_vec;
  logic        vec_load;
  boot_state_e state;

  boot_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  boot_seq_fsm #(
    .WAIT_CYC   (WAIT_CYC),
    .FA_W       (FA_W),
    .DATA_W     (DATA_W),
    .STATUS_LOC (STATUS_LOC),
    .VECTOR_LOC (VECTOR_LOC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .force_i    (force_ldr_i),
    .rdy_i      (flash_rdy_i),
    .data_i     (flash_data_i),
    .req_o      (flash_req_o),
    .addr_o     (flash_addr_o),
    .use_vec_o  (use_vec),
    .vec_load_o (vec_load),
    .state_o    (state)
  );

  boot_addr_pick #(.ADDR_W(ADDR_W), .VEC_W(DATA_W)) u_pick (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .vec_load_i  (vec_load),
    .use_vec_i   (use_vec),
    .vec_i       (flash_data_i),
    .state_i     (state),
    .boot_addr_o (boot_addr_o),
    .cpu_rst_n_o (cpu_rst_n_o)
  );
endmodule

// File: rtl/boot_addr_sel_chk.sv
module boot_addr_sel_chk #(
  parameter int ADDR_W = 16,
  parameter int FA_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flash_req_o,
  input logic [FA_W-1:0]   flash_addr_o,
  input logic              flash_rdy_i,
  input logic              cpu_rst_n_o,
  input logic [ADDR_W-1:0] boot_addr_o
);
  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_req_o && !flash_rdy_i) |=> (flash_req_o && $stable(flash_addr_o)));

  a_r6_addr_settled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n_o) |-> $stable(boot_addr_o));

  a_r6_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rst_n_o && $past(cpu_rst_n_o)) |-> $stable(boot_addr_o));

  a_r7_no_req_after: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_n_o |-> !flash_req_o);

  a_r7_release_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_n_o |=> cpu_rst_n_o);
endmodule

bind boot_addr_sel boot_addr_sel_chk #(.ADDR_W(ADDR_W), .FA_W(FA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flash_req_o  (flash_req_o),
  .flash_addr_o (flash_addr_o),
  .flash_rdy_i  (flash_rdy_i),
  .cpu_rst_n_o  (cpu_rst_n_o),
  .boot_addr_o  (boot_addr_o)
);

// File: tb/boot_addr_sel_tb.sv
module boot_addr_sel_tb;
  localparam int W = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        force_ldr = 1'b0;
  logic        flash_req;
  logic [3:0]  flash_addr;
  logic        flash_rdy = 1'b0;
  logic [7:0]  flash_data = 8'h5A;
  logic        cpu_rst_n;
  logic [15:0] boot_addr;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  boot_addr_sel #(.WAIT_CYC(W)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .force_ldr_i  (force_ldr),
    .flash_req_o  (flash_req),
    .flash_addr_o (flash_addr),
    .flash_rdy_i  (flash_rdy),
    .flash_data_i (flash_data),
    .cpu_rst_n_o  (cpu_rst_n),
    .boot_addr_o  (boot_addr)
  );

  always #2.5 clk = ~clk;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_reset_state(input string tag);
    chk({tag, " R8 cpu_rst_n"}, {31'b0, cpu_rst_n}, 0);
    chk({tag, " R8 req"}, {31'b0, flash_req}, 0);
    chk({tag, " R8 addr"}, {16'b0, boot_addr}, 0);
  endtask

  // One boot sequence; a reference model advanced on every falling edge.
  task automatic run_case(input string tag, input logic [7:0] status, input logic [7:0] vec,
                          input logic f_rel, input logic f_late, input int lat,
                          input bit cut_mid);
    int hs_cnt = 0;
    int rel_cnt = 0;
    int k = 0;
    int wcnt = 0;
    logic use_vec;
    logic [15:0] exp_addr;
    logic hs;
    @(negedge clk);
    rst_n = 1'b0;
    flash_rdy = 1'b0;
    force_ldr = f_rel;
    #1;
    check_reset_state(tag);
    repeat (3) @(negedge clk);
    check_reset_state(tag);
    rst_n = 1'b1;
    use_vec = (status != 8'h00) || f_rel;
    exp_addr = use_vec ? {vec, 8'h00} : 16'h0000;
    while (rel_cnt < 4) begin
      @(negedge clk);
      k++;
      if (k == 5) force_ldr = f_late;
      // compare against model
      chk({tag, " R6 cpu_rst_n"}, {31'b0, cpu_rst_n}, (hs_cnt == 2 && rel_cnt >= 1) ? 1 : 0);
      chk({tag, (f_rel ? " R3" : (f_late ? " R4" : (status != 0 ? " R2" : " R1"))), " addr"},
          {16'b0, boot_addr}, (hs_cnt == 2) ? {16'b0, exp_addr} : 32'h0);
      if (hs_cnt >= 2) chk({tag, " R7 req"}, {31'b0, flash_req}, 0);
      else if (k < W + 2) chk({tag, " R5 early req"}, {31'b0, flash_req}, 0);
      else if (k == W + 2) chk({tag, " R5 req rise"}, {31'b0, flash_req}, 1);
      if (flash_req && hs_cnt < 2)
        chk({tag, " R5 loc"}, {28'b0, flash_addr}, (hs_cnt == 0) ? 32'h0 : 32'h1);
      if (cut_mid && hs_cnt == 1 && wcnt >= 1) begin
        rst_n = 1'b0;
        #1;
        check_reset_state({tag, " mid"});
        return;
      end
      // flash model
      if (flash_req) begin
        if (wcnt >= lat) begin
          flash_rdy = 1'b1;
          flash_data = (flash_addr == 4'h0) ? status : vec;
          wcnt = 0;
        end else begin
          flash_rdy = 1'b0;
          flash_data = 8'h5A;
          wcnt++;
        end
      end else begin
        flash_rdy = 1'b0;
        flash_data = 8'hA5;
      end
      hs = flash_req && flash_rdy;
      if (hs_cnt >= 2) rel_cnt++;
      if (hs) hs_cnt++;
      if (k > 200) begin
        chk({tag, " R6 no release"}, 0, 1);
        return;
      end
    end
  endtask

  initial begin
    run_case("t1", 8'h00, 8'h1F, 1'b0, 1'b0, 0, 1'b0);
    run_case("t2", 8'h01, 8'h1F, 1'b0, 1'b0, 2, 1'b0);
    run_case("t3", 8'h80, 8'hFF, 1'b0, 1'b0, 1, 1'b0);
    run_case("t4", 8'h33, 8'h00, 1'b0, 1'b0, 0, 1'b0);
    run_case("t5", 8'h00, 8'h1F, 1'b1, 1'b0, 3, 1'b0);
    run_case("t6", 8'h00, 8'h1E, 1'b0, 1'b1, 1, 1'b0);
    run_case("t7", 8'hFF, 8'h1F, 1'b0, 1'b0, 2, 1'b1);
    run_case("t8", 8'h00, 8'h7C, 1'b1, 1'b1, 0, 1'b0);
    finish_run();
  end
endmodule